// File: doc/BRIEF.md
# I2C Bus State and Hang Monitor

This block watches the SCL and SDA lines of an I2C bus and keeps the bus-level status that a controller needs beside its shift and acknowledge logic. Both lines are first resynchronised to the system clock. The block then recognises START and STOP conditions, tracks whether a transfer is in progress, and reports whether the bus is idle. A START or STOP is a bus error when it appears inside a byte or an acknowledge slot; the protocol engine reports those slots through a frame-position input.

Two further watchers run beside the edge detection. The first is a short hang counter. It advances on sample-clock enables while SCL stays high and restarts on each SCL falling edge. When it wraps while SDA is low, it reports a stuck bus. The second is a programmable timeout. It counts system clock cycles from the moment every interrupt flag is clear and raises its own flag when the programmed limit is reached.

All four event flags are write-one-to-clear, and each drives the interrupt output only through its enable bit.

Top module: `i2c_bus_watch`

## Requirements
- R1: After reset all four flags are 0, the busy and hang outputs are 0, and bus_idle is 1 while both lines are high.
- R2: A START (SDA falling while SCL is high) sets flags[0] and bus_busy. A STOP (SDA rising while SCL is high) sets flags[1] and clears bus_busy.
- R3: bus_idle is 1 only when both synchronised lines are high and bus_busy is 0.
- R4: A change of SDA while SCL is low is not a condition: flags and bus_busy are unchanged.
- R5: A 4-bit counter advances on each samp_en cycle while SCL is high and restarts on every SCL falling edge. The 16th such enable in one SCL-high period, with SDA low, sets bus_hang.
- R6: A counter wrap while SDA is high leaves bus_hang at 0.
- R7: bus_hang is cleared by the next START and has no flag bit and no interrupt.
- R8: A START or STOP while in_frame is 1 sets flags[2]. The flag stays set until it is cleared.
- R9: With tmo_limit nonzero, flags[3] is set tmo_limit+1 clock cycles after the edge at which all flags became 0. With tmo_limit zero it is never set.
- R10: While any flag is set the timeout counter is held at zero. The timeout flag therefore rises once and holds.
- R11: A 1 in flag_clr clears the matching flag, and a 0 leaves it alone. A set in the same cycle wins over a clear.
- R12: irq is the OR over i of flags[i] AND irq_en[i]. Bit order is 0 start, 1 stop, 2 error, 3 timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| samp_en | input | 1 | Sample-clock enable for the hang counter |
| in_frame | input | 1 | High during an address byte, data byte or acknowledge bit |
| tmo_limit | input | TMO_W | Timeout limit in clock cycles; 0 disables |
| irq_en | input | 4 | Interrupt enables, one per flag |
| flag_clr | input | 4 | Write-one-to-clear pulses, one per flag |
| flags | output | 4 | Start, stop, error and timeout flags |
| bus_busy | output | 1 | Transfer in progress |
| bus_idle | output | 1 | Both lines high and not busy |
| bus_hang | output | 1 | SCL held high with SDA low past the hang count |
| irq | output | 1 | Enabled-flag interrupt |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser, a 4-bit hang counter and a 10-bit timeout. With these values the hang limit is 16 enables and the timeout can be set to small limits such as 1 or 5, so the exact cycle of each boundary can be checked in a short run. The randomly generated line toggles and frame positions are compared against a bench model of the START, STOP, busy and error rules. The short hang count also allows one test to start two partial counts that are split by an SCL falling edge, which shows that the edge restarts the counter.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int FLG_N   = 4;
  localparam int FLG_STA = 0;
  localparam int FLG_STO = 1;
  localparam int FLG_ERR = 2;
  localparam int FLG_TMO = 3;

  typedef logic [FLG_N-1:0] flag_vec_t;

  // SDA falls while SCL is high on both sides of the edge
  function automatic logic is_start(input logic scl_now, input logic scl_was,
                                    input logic sda_now, input logic sda_was);
    return scl_now & scl_was & sda_was & ~sda_now;
  endfunction

  // SDA rises while SCL is high on both sides of the edge
  function automatic logic is_stop(input logic scl_now, input logic scl_was,
                                   input logic sda_now, input logic sda_was);
    return scl_now & scl_was & ~sda_was & sda_now;
  endfunction

  // write-one-to-clear update; a new set wins over a clear
  function automatic flag_vec_t w1c_next(input flag_vec_t cur, input flag_vec_t clr,
                                         input flag_vec_t set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/bm_sync.sv
module bm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  // lines reset to their idle level so that no condition appears at reset release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_fall = scl_q & ~scl_s;
  assign start_ev = bm_pkg::is_start(scl_s, scl_q, sda_s, sda_q);
  assign stop_ev  = bm_pkg::is_stop(scl_s, scl_q, sda_s, sda_q);
endmodule

// File: rtl/bm_hang.sv
module bm_hang #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  input  logic scl_fall,
  input  logic samp_en,
  input  logic start_ev,
  output logic hang
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic advance, wrap;

  assign advance = samp_en & scl_s;
  assign wrap    = advance & (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (scl_fall) cnt <= '0;
    else if (advance)  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hang <= 1'b0;
    else if (start_ev)         hang <= 1'b0;
    else if (wrap && !sda_s)   hang <= 1'b1;
  end

  // R5: a falling SCL edge restarts the count
  a_r5_fall_restart: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |=> (cnt == '0));
  // R7: the next START removes the hang status
  a_r7_hang_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !hang);
endmodule

// File: rtl/bm_timeout.sv
module bm_timeout #(
  parameter int TMO_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMO_W-1:0] limit,
  input  logic             all_clear,
  output logic             hit
);
  logic [TMO_W-1:0] cnt;
  logic run;

  assign run = all_clear && (limit != '0);
  assign hit = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run || hit) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  // R10: any pending flag holds the counter at zero
  a_r10_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !all_clear |=> (cnt == '0));
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch #(
  parameter int SYNC_STAGES = 2,
  parameter int HANG_W      = 4,
  parameter int TMO_W       = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             samp_en,
  input  logic             in_frame,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic [3:0]       irq_en,
  input  logic [3:0]       flag_clr,
  output logic [3:0]       flags,
  output logic             bus_busy,
  output logic             bus_idle,
  output logic             bus_hang,
  output logic             irq
);
  import bm_pkg::*;

  logic scl_s, sda_s, scl_fall, start_ev, stop_ev;
  logic frame_err_ev, tmo_hit;
  flag_vec_t flags_q, set_vec;

  bm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  bm_hang #(.CNT_W(HANG_W)) u_hang (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_fall(scl_fall), .samp_en(samp_en), .start_ev(start_ev),
    .hang(bus_hang)
  );

  bm_timeout #(.TMO_W(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .limit(tmo_limit),
    .all_clear(flags_q == '0), .hit(tmo_hit)
  );

  assign frame_err_ev = (start_ev | stop_ev) & in_frame;

  always_comb begin
    set_vec          = '0;
    set_vec[FLG_STA] = start_ev;
    set_vec[FLG_STO] = stop_ev;
    set_vec[FLG_ERR] = frame_err_ev;
    set_vec[FLG_TMO] = tmo_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= w1c_next(flags_q, flag_clr, set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bus_busy <= 1'b0;
    else if (start_ev) bus_busy <= 1'b1;
    else if (stop_ev)  bus_busy <= 1'b0;
  end

  assign flags    = flags_q;
  assign bus_idle = scl_s & sda_s & ~bus_busy;
  assign irq      = |(flags_q & irq_en);

  // R2: START marks the bus busy
  a_r2_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> bus_busy);
  // R2: STOP releases the bus
  a_r2_busy_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && !start_ev) |=> !bus_busy);
  // R8: the error flag is sticky until cleared
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[FLG_ERR] && !flag_clr[FLG_ERR]) |=> flags_q[FLG_ERR]);
  // R11: a clear without a new START removes the start flag
  a_r11_clear_start: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[FLG_STA] && !start_ev) |=> !flags_q[FLG_STA]);
endmodule

// File: tb/test_i2c_bus_watch.sv
module test_i2c_bus_watch;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int HW         = 4;
  localparam int TW         = 10;
  localparam int SETTLE     = SYNC + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, samp_en = 1'b0, in_frame = 1'b0;
  logic [TW-1:0] tmo_limit = '0;
  logic [3:0] irq_en = '0, flag_clr = '0;
  logic [3:0] flags;
  logic bus_busy, bus_idle, bus_hang, irq;

  int tests = 0;
  int fails = 0;

  // bench model
  logic m_busy = 1'b0;
  logic [3:0] m_flags = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_bus_watch #(.SYNC_STAGES(SYNC), .HANG_W(HW), .TMO_W(TW)) i_i2c_bus_watch (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .samp_en(samp_en),
    .in_frame(in_frame), .tmo_limit(tmo_limit), .irq_en(irq_en), .flag_clr(flag_clr),
    .flags(flags), .bus_busy(bus_busy), .bus_idle(bus_idle), .bus_hang(bus_hang), .irq(irq)
  );

  function automatic int hang_enables();
    return 1 << HW;
  endfunction

  function automatic int tmo_delay(input int lim);
    return lim + 1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive both lines, apply the bench model, wait for the design to settle
  task automatic lines(input logic c, input logic d);
    logic st, sp;
    st = scl & c & sda & ~d;
    sp = scl & c & ~sda & d;
    scl = c;
    sda = d;
    if (st) begin m_busy = 1'b1; m_flags[0] = 1'b1; end
    if (sp) begin m_busy = 1'b0; m_flags[1] = 1'b1; end
    if ((st || sp) && in_frame) m_flags[2] = 1'b1;
    tick(SETTLE);
  endtask

  task automatic clear(input logic [3:0] m);
    flag_clr = m;
    tick(1);
    flag_clr = '0;
    m_flags = m_flags & ~m;
  endtask

  task automatic pulses(input int n);
    samp_en = 1'b1;
    tick(n);
    samp_en = 1'b0;
    tick(1);
  endtask

  task automatic tmo_run(input int lim);
    lines(1'b0, 1'b1);
    lines(1'b1, 1'b1);
    lines(1'b1, 1'b0);   // START gives a pending flag
    tmo_limit = lim[TW-1:0];
    clear(4'hF);
    tick(tmo_delay(lim) - 1);
    check("R9 timeout not yet", {28'd0, flags}, 32'h0);
    tick(1);
    check("R9 timeout at limit+1", {28'd0, flags}, 32'h8);
    tick(40);
    check("R10 timeout holds once", {28'd0, flags}, 32'h8);
    clear(4'h8);
    tick(tmo_delay(lim) - 1);
    check("R10 restart not yet", {28'd0, flags}, 32'h0);
    tick(1);
    check("R10 restart after clear", {28'd0, flags}, 32'h8);
    clear(4'hF);
    tmo_limit = '0;
    lines(1'b1, 1'b1);   // STOP returns to idle
    clear(4'hF);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    check("R1 flags", {28'd0, flags}, 32'h0);
    check("R1 busy", bus_busy, 0);
    check("R1 hang", bus_hang, 0);
    check("R3 idle at reset", bus_idle, 1);

    // R2 START
    lines(1'b1, 1'b0);
    check("R2 start flag", {28'd0, flags}, 32'h1);
    check("R2 busy after start", bus_busy, 1);
    check("R3 not idle when busy", bus_idle, 0);
    // R4 SDA moves with SCL low
    lines(1'b0, 1'b0);
    lines(1'b0, 1'b1);
    lines(1'b0, 1'b0);
    check("R4 no condition with scl low", {28'd0, flags}, 32'h1);
    check("R4 busy kept", bus_busy, 1);
    lines(1'b1, 1'b0);
    lines(1'b1, 1'b1);
    check("R2 stop flag", {28'd0, flags}, 32'h3);
    check("R2 busy cleared by stop", bus_busy, 0);
    check("R3 idle after stop", bus_idle, 1);

    // R11 write one to clear
    clear(4'h1);
    check("R11 clear bit0", {28'd0, flags}, 32'h2);
    clear(4'h0);
    check("R11 zero clear no effect", {28'd0, flags}, 32'h2);
    irq_en = 4'h1;
    tick(1);
    check("R12 irq masked", irq, 0);
    irq_en = 4'h2;
    tick(1);
    check("R12 irq enabled", irq, 1);
    irq_en = 4'h0;
    clear(4'hF);

    // R8 error inside a frame
    in_frame = 1'b1;
    lines(1'b1, 1'b0);
    in_frame = 1'b0;
    check("R8 error on start in frame", {28'd0, flags}, 32'h5);
    tick(10);
    check("R8 error sticky", flags[2], 1);
    clear(4'hF);

    // R11 set wins: STOP event meets a clear on the same edge
    sda = 1'b1;
    tick(SYNC);
    flag_clr = 4'h2;
    tick(1);
    flag_clr = 4'h0;
    tick(2);
    check("R11 set wins over clear", flags[1], 1);
    m_busy = 1'b0;
    clear(4'hF);

    // R5 hang counter: restart on SCL fall, then reach the limit with SDA low
    lines(1'b0, 1'b1);
    lines(1'b0, 1'b0);
    lines(1'b1, 1'b0);
    pulses(hang_enables() - 6);
    lines(1'b0, 1'b0);
    lines(1'b1, 1'b0);
    pulses(hang_enables() - 6);
    check("R5 fall restarts count", bus_hang, 0);
    pulses(5);
    check("R5 one short of limit", bus_hang, 0);
    pulses(1);
    check("R5 hang at limit", bus_hang, 1);
    check("R7 hang raises no flag", {28'd0, flags}, 32'h0);
    irq_en = 4'hF;
    tick(1);
    check("R7 hang raises no irq", irq, 0);
    irq_en = 4'h0;
    lines(1'b0, 1'b0);
    lines(1'b0, 1'b1);
    lines(1'b1, 1'b1);
    check("R7 hang holds until start", bus_hang, 1);
    lines(1'b1, 1'b0);
    check("R7 start clears hang", bus_hang, 0);
    // R6 wrap with SDA high
    lines(1'b0, 1'b0);
    lines(1'b0, 1'b1);
    lines(1'b1, 1'b1);
    pulses(hang_enables() + 4);
    check("R6 no hang with sda high", bus_hang, 0);
    lines(1'b0, 1'b1);
    lines(1'b0, 1'b0);
    lines(1'b1, 1'b0);
    lines(1'b1, 1'b1);
    clear(4'hF);

    // random line activity against the model
    for (int i = 0; i < 200; i++) begin
      in_frame = ($urandom % 4) == 0;
      if ($urandom % 2) lines(~scl, sda);
      else              lines(scl, ~sda);
      in_frame = 1'b0;
      irq_en = 4'($urandom);
      tick(1);
      check("R2 random busy", bus_busy, m_busy);
      check("R3 random idle", bus_idle, scl & sda & ~m_busy);
      check("R8 random flags", {28'd0, flags}, {28'd0, m_flags});
      check("R12 random irq", irq, |(m_flags & irq_en));
      if (($urandom % 3) == 0) clear(4'($urandom));
    end
    irq_en = '0;
    clear(4'hF);

    // R9 / R10 timeout
    tmo_run(1);
    tmo_run(5);
    tmo_run(2 + ($urandom % 39));
    tick(100);
    check("R9 limit zero never times out", {28'd0, flags}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule